// File: doc/BRIEF.md
# Re-reference Prediction Victim Selector

This block keeps the replacement state for every set of a set-associative cache and names the way to evict when a line must be brought in. Each way of each set carries a small saturating prediction value: a low value means the line is expected to be reused soon, and the largest value means it is the next candidate to leave. A hit on a way marks it as likely to be reused by clearing its value. A fill asks the block for a victim in one set, and the block answers one cycle later.

The width of the prediction value is a parameter. With one bit the block behaves as a not-recently-used policy: a hit clears the bit, and when no bit in the set is left at one, the whole set is set back to one. With three bits it behaves as a multi-level predictor. A filled line does not start at the protected end: it receives one step below the eviction value, so a line that is never touched again is evicted early. If no way holds the eviction value at fill time, all ways of the set age by the same amount in that cycle until the oldest reaches it.

Tag and data storage, and any run-time choice between insertion policies, stay outside the block. The cache controller drives a hit strobe with set and way for every hit, and a fill strobe with a set for every miss that needs a line.

Top module: `reref_victim_ctrl`

## Requirements
- R1: Reset sets every prediction value of every set to the eviction value (all ones, 2^CW-1), so the first fills into a fresh set return ways 0, 1, 2, ... in order.
- R2: A hit on a way clears that way's value to zero in the cycle after the hit strobe.
- R3: With CW=1, when a hit or a fill leaves every bit of a set at zero, all bits of that set are set to one in the same update.
- R4: The victim is the lowest-numbered way whose value equals the eviction value after any aging.
- R5: When no way of the filled set holds the eviction value, every value in that set is raised by the same amount so that the largest reaches the eviction value, in the same update as the fill.
- R6: The victim way of a fill is written with the insertion value 2^CW-2 (6 for CW=3, 0 for CW=1).
- R7: victim_vld is high exactly in the cycle after each cycle with fill_req high, and low otherwise, including after reset; victim_way is valid while victim_vld is high. Back-to-back fills are each answered.
- R8: A hit and a fill in the same cycle to the same set are both applied: the hit is applied first, and the victim search and aging see the values after the hit.
- R9: A set that receives neither a hit nor a fill in a cycle keeps its values unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| hit_vld | input | 1 | A hit occurred this cycle |
| hit_set | input | SIDX | Set index of the hit |
| hit_way | input | WIDX | Way that hit |
| fill_req | input | 1 | Request a victim for a line being filled |
| fill_set | input | SIDX | Set index of the fill |
| victim_vld | output | 1 | Victim answer valid, one cycle after fill_req |
| victim_way | output | WIDX | Chosen victim way |

## Verification
A hit and a victim search can fall in the same cycle, either on different sets or on the same set, where the order of the two updates changes which way is evicted. The bench provokes this with a directed cycle that hits way 0 of a fresh set while filling it, which must return way 1, and then with a long random run that drives both strobes independently over only four sets so that same-set collisions are frequent. A behavioural model that applies the hit before the search predicts the victim every cycle, for both a one-bit and a three-bit instance driven with the same stimulus.

// File: rtl/reref_pkg.sv
`timescale 1ns/1ps
// Package: value helpers shared by the victim selector and its sub-blocks.
// Assumes the counter width is between 1 and 8 bits.
package reref_pkg;

    // Eviction (top) value for a given counter width.
    function automatic int unsigned top_val(int unsigned cw);
        return (1 << cw) - 1;
    endfunction

    // Insertion value: one step below the eviction value.
    function automatic int unsigned ins_val(int unsigned cw);
        return (1 << cw) - 2;
    endfunction

endpackage

// File: rtl/reref_hit_upd.sv
`timescale 1ns/1ps
// Module: applies a hit to the prediction values of one set.
// The hit way is cleared to zero; in one-bit mode an all-zero set
// is restored to all ones. Purely combinational.
module reref_hit_upd #(
    parameter int WAYS = 4,
    parameter int CW   = 3,
    localparam int WIDX = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic                 hit_en,
    input  logic [WIDX-1:0]      hit_way,
    input  logic [WAYS*CW-1:0]   cur,
    output logic [WAYS*CW-1:0]   nxt
);

    logic [WAYS*CW-1:0] cleared;

    // Clear the value of the way that hit.
    always_comb begin
        cleared = cur;
        if (hit_en) begin
            cleared[hit_way*CW +: CW] = '0;
        end
    end

    generate
        if (CW == 1) begin : g_single
            // One-bit mode: restore the set when nothing is left at one.
            always_comb nxt = (cleared == '0) ? '1 : cleared;
        end else begin : g_multi
            // Multi-bit mode: no renormalisation.
            always_comb nxt = cleared;
        end
    endgenerate

endmodule

// File: rtl/reref_victim_sel.sv
`timescale 1ns/1ps
// Module: victim search, aging and insertion for one set.
// Finds the largest value, ages all ways so that it reaches the
// eviction value, picks the lowest-numbered way holding it and writes
// the insertion value there. Purely combinational; assumes CW <= 8.
module reref_victim_sel #(
    parameter int WAYS = 4,
    parameter int CW   = 3,
    localparam int WIDX = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic [WAYS*CW-1:0]   cur,
    output logic [WIDX-1:0]      vic,
    output logic [WAYS*CW-1:0]   nxt
);

    localparam logic [CW-1:0] TOP = CW'(reref_pkg::top_val(CW));
    localparam logic [CW-1:0] INS = CW'(reref_pkg::ins_val(CW));

    logic [CW-1:0]      mx;
    logic [CW-1:0]      delta;
    logic               found;
    logic [WAYS*CW-1:0] aged;

    // Largest value, aging step, lowest way at the largest value, insertion.
    always_comb begin
        mx = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (cur[w*CW +: CW] > mx) mx = cur[w*CW +: CW];
        end
        delta = TOP - mx;
        vic   = '0;
        found = 1'b0;
        for (int w = 0; w < WAYS; w++) begin
            if (!found && cur[w*CW +: CW] == mx) begin
                vic   = WIDX'(w);
                found = 1'b1;
            end
        end
        aged = '0;
        for (int w = 0; w < WAYS; w++) begin
            aged[w*CW +: CW] = cur[w*CW +: CW] + delta;
        end
        aged[vic*CW +: CW] = INS;
    end

    generate
        if (CW == 1) begin : g_single
            // One-bit mode: a fill that zeroes the set restores it.
            always_comb nxt = (aged == '0) ? '1 : aged;
        end else begin : g_multi
            // Multi-bit mode: aged values go straight out.
            always_comb nxt = aged;
        end
    endgenerate

endmodule

// File: rtl/reref_victim_ctrl.sv
`timescale 1ns/1ps
// Module: replacement-state controller for all sets of a cache.
// Holds CW-bit prediction values per way per set, applies hits, and
// answers each fill with a victim way one cycle later. A hit and a
// fill in the same cycle on the same set are ordered hit first.
// Assumes SETS and WAYS are powers of two, at least 2.
module reref_victim_ctrl #(
    parameter int SETS = 8,
    parameter int WAYS = 4,
    parameter int CW   = 3,
    localparam int SIDX = (SETS > 1) ? $clog2(SETS) : 1,
    localparam int WIDX = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hit_vld,
    input  logic [SIDX-1:0] hit_set,
    input  logic [WIDX-1:0] hit_way,
    input  logic            fill_req,
    input  logic [SIDX-1:0] fill_set,
    output logic            victim_vld,
    output logic [WIDX-1:0] victim_way
);

    localparam int SW = WAYS * CW;

    logic [SW-1:0]        st_q     [SETS];
    logic [SW-1:0]        post_hit [SETS];
    logic [SW-1:0]        st_d     [SETS];
    logic [SW-1:0]        fill_cur;
    logic [SW-1:0]        sel_nxt;
    logic [WIDX-1:0]      sel_way;
    logic [SETS*SW-1:0]   st_flat;

    generate
        for (genvar s = 0; s < SETS; s++) begin : g_set
            reref_hit_upd #(.WAYS(WAYS), .CW(CW)) u_hit (
                .hit_en  (hit_vld && (hit_set == SIDX'(s))),
                .hit_way (hit_way),
                .cur     (st_q[s]),
                .nxt     (post_hit[s])
            );

            // Fill result replaces the post-hit values of the filled set.
            always_comb st_d[s] = (fill_req && (fill_set == SIDX'(s))) ? sel_nxt : post_hit[s];

            // State register; reset puts every way at the eviction value.
            always_ff @(posedge clk) begin
                if (!rst_n) st_q[s] <= '1;
                else        st_q[s] <= st_d[s];
            end

            assign st_flat[s*SW +: SW] = st_q[s];
        end
    endgenerate

    // Victim search sees the filled set after any same-cycle hit.
    always_comb fill_cur = post_hit[fill_set];

    reref_victim_sel #(.WAYS(WAYS), .CW(CW)) u_sel (
        .cur (fill_cur),
        .vic (sel_way),
        .nxt (sel_nxt)
    );

    // Registered answer: valid one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            victim_vld <= 1'b0;
            victim_way <= '0;
        end else begin
            victim_vld <= fill_req;
            if (fill_req) victim_way <= sel_way;
        end
    end

endmodule

// File: rtl/reref_victim_chk.sv
`timescale 1ns/1ps
// Module: property checker for reref_victim_ctrl, attached by bind.
// Observes ports and the flattened per-set state.
module reref_victim_chk #(
    parameter int SETS = 8,
    parameter int WAYS = 4,
    parameter int CW   = 3,
    localparam int SIDX = (SETS > 1) ? $clog2(SETS) : 1,
    localparam int WIDX = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  hit_vld,
    input logic [SIDX-1:0]       hit_set,
    input logic [WIDX-1:0]       hit_way,
    input logic                  fill_req,
    input logic [SIDX-1:0]       fill_set,
    input logic                  victim_vld,
    input logic [WIDX-1:0]       victim_way,
    input logic [SETS*WAYS*CW-1:0] st_flat
);

    localparam int SW = WAYS * CW;
    localparam logic [CW-1:0] INS = CW'(reref_pkg::ins_val(CW));

    p_vld_after_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req |=> victim_vld);

    p_vld_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !fill_req |=> !victim_vld);

    generate
        for (genvar s = 0; s < SETS; s++) begin : g_set
            p_idle_set_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
                (!(hit_vld && hit_set == SIDX'(s)) && !(fill_req && fill_set == SIDX'(s)))
                |=> $stable(st_flat[s*SW +: SW]));
            if (CW == 1) begin : g_single
                p_never_all_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
                    st_flat[s*SW +: SW] != '0);
            end
        end
        if (CW > 1) begin : g_multi
            p_fill_inserts_r6: assert property (@(posedge clk) disable iff (!rst_n)
                fill_req |=> st_flat[($past(fill_set)*WAYS + victim_way)*CW +: CW] == INS);
            p_hit_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
                (hit_vld && !(fill_req && fill_set == hit_set))
                |=> st_flat[($past(hit_set)*WAYS + $past(hit_way))*CW +: CW] == '0);
        end
    endgenerate

endmodule

bind reref_victim_ctrl reref_victim_chk #(.SETS(SETS), .WAYS(WAYS), .CW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hit_vld    (hit_vld),
    .hit_set    (hit_set),
    .hit_way    (hit_way),
    .fill_req   (fill_req),
    .fill_set   (fill_set),
    .victim_vld (victim_vld),
    .victim_way (victim_way),
    .st_flat    (st_flat)
);

// File: tb/reref_victim_ctrl_tb.sv
`timescale 1ns/1ps
// Bench: drives a three-bit and a one-bit instance with shared stimulus
// and compares both against a behavioural model on every clock.
module reref_victim_ctrl_tb;

    localparam int SETS = 4;
    localparam int WAYS = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hit_vld = 1'b0;
    logic [1:0] hit_set = '0;
    logic [1:0] hit_way = '0;
    logic       fill_req = 1'b0;
    logic [1:0] fill_set = '0;
    logic       vld [2];
    logic [1:0] way [2];

    always #2 clk = ~clk;

    reref_victim_ctrl #(.SETS(SETS), .WAYS(WAYS), .CW(3)) u_dut (
        .clk(clk), .rst_n(rst_n), .hit_vld(hit_vld), .hit_set(hit_set),
        .hit_way(hit_way), .fill_req(fill_req), .fill_set(fill_set),
        .victim_vld(vld[0]), .victim_way(way[0]));

    reref_victim_ctrl #(.SETS(SETS), .WAYS(WAYS), .CW(1)) u_dut_nru (
        .clk(clk), .rst_n(rst_n), .hit_vld(hit_vld), .hit_set(hit_set),
        .hit_way(hit_way), .fill_req(fill_req), .fill_set(fill_set),
        .victim_vld(vld[1]), .victim_way(way[1]));

    int    m [2][SETS][WAYS];
    int    topv [2] = '{7, 1};
    bit    ev [2];
    int    ew [2];
    int    errs = 0;
    int    checks = 0;
    string ptag = "R7";

    function automatic bit set_zero(int k, int s);
        for (int w = 0; w < WAYS; w++) if (m[k][s][w] != 0) return 1'b0;
        return 1'b1;
    endfunction

    // Model: hit first, then aging, lowest top-valued way, insertion.
    function automatic void model_step(int k, bit hv, int hs, int hw, bit fr, int fs);
        int mx;
        ev[k] = fr;
        if (hv) begin
            m[k][hs][hw] = 0;
            if (k == 1 && set_zero(k, hs)) for (int w = 0; w < WAYS; w++) m[k][hs][w] = 1;
        end
        if (fr) begin
            mx = 0;
            for (int w = 0; w < WAYS; w++) if (m[k][fs][w] > mx) mx = m[k][fs][w];
            for (int w = 0; w < WAYS; w++) m[k][fs][w] += topv[k] - mx;
            ew[k] = -1;
            for (int w = 0; w < WAYS; w++) if (ew[k] < 0 && m[k][fs][w] == topv[k]) ew[k] = w;
            m[k][fs][ew[k]] = topv[k] - 1;
            if (k == 1 && set_zero(k, fs)) for (int w = 0; w < WAYS; w++) m[k][fs][w] = 1;
        end
    endfunction

    task automatic compare(string tag);
        for (int k = 0; k < 2; k++) begin
            checks++;
            if (vld[k] !== ev[k]) begin
                errs++;
                $display("FAIL %s cw_mode=%0d victim_vld actual=%0b expected=%0b", tag, k, vld[k], ev[k]);
            end else if (ev[k]) begin
                checks++;
                if (way[k] !== 2'(ew[k])) begin
                    errs++;
                    $display("FAIL %s cw_mode=%0d victim_way actual=%0d expected=%0d", tag, k, way[k], ew[k]);
                end
            end
        end
    endtask

    // One cycle: check the previous answer, then drive and update the model.
    task automatic step(string tag, bit hv, int hs, int hw, bit fr, int fs);
        @(negedge clk);
        compare(ptag);
        ptag     = tag;
        hit_vld  = hv;
        hit_set  = 2'(hs);
        hit_way  = 2'(hw);
        fill_req = fr;
        fill_set = 2'(fs);
        for (int k = 0; k < 2; k++) model_step(k, hv, hs, hw, fr, fs);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errs++;
        $display("FAIL R7 watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        for (int k = 0; k < 2; k++) begin
            ev[k] = 1'b0;
            ew[k] = 0;
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++) m[k][s][w] = topv[k];
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare("R7 reset state");
        rst_n = 1'b1;
        // R1: fresh set fills in way order; R3: fourth fill restores one-bit set.
        step("R1", 0, 0, 0, 1, 0);
        step("R1", 0, 0, 0, 1, 0);
        step("R1", 0, 0, 0, 1, 0);
        step("R3", 0, 0, 0, 1, 0);
        // R5 and R6: all ways at the insertion value age back to way 0.
        step("R5", 0, 0, 0, 1, 0);
        step("R7 idle", 0, 0, 0, 0, 0);
        // R2: clear ways 0 and 1 of set 1, then fill picks way 2.
        step("R2", 1, 1, 0, 0, 0);
        step("R2", 1, 1, 1, 0, 0);
        step("R2", 0, 0, 0, 1, 1);
        step("R4", 0, 0, 0, 1, 1);
        step("R6", 0, 0, 0, 1, 1);
        // R8: hit and fill to a fresh set in one cycle; victim is way 1.
        step("R8", 1, 2, 0, 1, 2);
        // R9: set 3 untouched so far still starts at way 0.
        step("R9", 1, 2, 3, 1, 3);
        step("R7 idle", 0, 0, 0, 0, 0);
        // Random run over both strobes with frequent same-set collisions.
        for (int i = 0; i < 4000; i++) begin
            step("R5 random", ($urandom_range(0, 2) != 0), $urandom_range(0, SETS-1),
                 $urandom_range(0, WAYS-1), ($urandom_range(0, 1) != 0), $urandom_range(0, SETS-1));
        end
        step("R7 idle", 0, 0, 0, 0, 0);
        step("R7 idle", 0, 0, 0, 0, 0);
        finish_run();
    end

endmodule